// File: doc/BRIEF.md
# Slow Control Input Qualifier

This block sits between two slow, noisy terminal control lines and the logic they act on. One line asks for the count to be cleared. The other line is a comparator gate. Each line goes through its own synchronizer. A line counts as active only after it has been seen high on a given number of consecutive clock samples. Once a line is accepted, its qualified output stays active for a long hold-off after the line drops. The accept delay is therefore short and the release delay is long.

The qualified clear channel drives a clear output for an external counter. The qualified gate channel does not come out as a port of its own. Instead it forces every pass/fail decision output to zero while it is active. When it is not active, the raw decision inputs pass straight through. With the default parameters and a 1 MHz clock, a line must stay high for 4 ms to be accepted, and the release hold-off is about 100 ms. Both values stay inside the required 4 ms accept bound and 150 ms release bound.

Top module: `ctrl_input_qualifier`

## Requirements
- R1: After system reset the clear output is low, and every decision output equals its decision input.
- R2: A raw line that is high for fewer than QUAL_CYCLES consecutive clock samples never makes its channel active.
- R3: A single low sample while a line is qualifying restarts the count from zero, so two short high runs split by one low sample are not accepted.
- R4: When the first high sample of a qualifying run is at edge c, the channel becomes active at edge c + SYNC_STAGES + QUAL_CYCLES - 1.
- R5: When the line of an active channel is first sampled low at edge m, the channel goes inactive at edge m + SYNC_STAGES + HOLD_CYCLES, unless R6 applies.
- R6: A line sampled high again while the release hold-off is running keeps the channel active without a new qualify interval. The release time then restarts from the last drop.
- R7: While the gate channel (channel 1) is active, all decision outputs are 0 for any decision input. Otherwise they equal the decision inputs.
- R8: The clear channel (channel 0) and the gate channel qualify and release independently, including when their pulses overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| rawClear | input | 1 | Unsynchronized clear-request line |
| rawGate | input | 1 | Unsynchronized comparator gate line |
| decisionIn | input | NUM_DEC | Pass/fail results from the comparator |
| counterClear | output | 1 | Qualified clear for the counter |
| decisionOut | output | NUM_DEC | Decision results after gating |

## Verification
The channels are driven with these patterns:
- A pulse exactly QUAL_CYCLES long. It pins both the accept edge and the release edge to the exact cycle.
- A pulse one sample shorter than QUAL_CYCLES. It separates a correct compare limit from an off-by-one.
- Two short runs split by a single low sample. This shows that the qualify count restarts instead of accumulating.
- A drop followed by a re-assertion inside the hold-off. This separates release cancellation from a fresh qualify.

Gate pulses that overlap clear pulses show that the two channels keep their own state. While the gate is active, changing decision patterns are applied. A pattern applied after the gate has released shows that the decisions pass through again.

// File: rtl/qual_pkg.sv
package qual_pkg;

  localparam int NUM_CHAN = 2;
  localparam int CH_CLEAR = 0;
  localparam int CH_GATE  = 1;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_RELEASE = 2'd2
  } chanState_t;

  // Strobes from control to the counter datapath of one channel
  typedef struct packed {
    logic qualInc;
    logic qualZero;
    logic holdInc;
    logic holdZero;
  } cntStrobe_t;

endpackage

// File: rtl/qual_datapath.sv
module qual_datapath
  import qual_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 4000,
  parameter int HOLD_CYCLES = 100000,
  parameter int NUM_DEC     = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CHAN-1:0]            rawIn,
  input  cntStrobe_t [NUM_CHAN-1:0]      strobe,
  input  logic                           gateActive,
  input  logic [NUM_DEC-1:0]             decisionIn,
  output logic [NUM_CHAN-1:0]            syncLevel,
  output logic [NUM_CHAN-1:0]            qualDone,
  output logic [NUM_CHAN-1:0]            holdDone,
  output logic [NUM_DEC-1:0]             decisionOut
);

  localparam int QW = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;
  localparam int HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_CYCLES - 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic [SYNC_STAGES-1:0] pipe;
    logic [QW-1:0]          qualCnt;
    logic [HW-1:0]          holdCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pipe    <= '0;
        qualCnt <= '0;
        holdCnt <= '0;
      end else begin
        pipe <= {pipe[SYNC_STAGES-2:0], rawIn[c]};
        if (strobe[c].qualZero)      qualCnt <= '0;
        else if (strobe[c].qualInc)  qualCnt <= qualCnt + 1'b1;
        if (strobe[c].holdZero)      holdCnt <= '0;
        else if (strobe[c].holdInc)  holdCnt <= holdCnt + 1'b1;
      end
    end

    assign syncLevel[c] = pipe[SYNC_STAGES-1];
    assign qualDone[c]  = (qualCnt == QUAL_LAST);
    assign holdDone[c]  = (holdCnt == HOLD_LAST);
  end

  // Gate override of the pass/fail decisions
  assign decisionOut = gateActive ? '0 : decisionIn;

endmodule

// File: rtl/qual_control.sv
module qual_control
  import qual_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CHAN-1:0]       syncLevel,
  input  logic [NUM_CHAN-1:0]       qualDone,
  input  logic [NUM_CHAN-1:0]       holdDone,
  output cntStrobe_t [NUM_CHAN-1:0] strobe,
  output logic [NUM_CHAN-1:0]       chanActive
);

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_fsm
    chanState_t stateQ, stateD;
    cntStrobe_t st;

    always_comb begin
      stateD = stateQ;
      st     = '0;
      unique case (stateQ)
        ST_IDLE: begin
          st.holdZero = 1'b1;
          if (!syncLevel[c]) begin
            st.qualZero = 1'b1;        // any low sample restarts qualify
          end else if (qualDone[c]) begin
            st.qualZero = 1'b1;
            stateD      = ST_ACTIVE;
          end else begin
            st.qualInc  = 1'b1;
          end
        end
        ST_ACTIVE: begin
          st.qualZero = 1'b1;
          st.holdZero = 1'b1;
          if (!syncLevel[c]) stateD = ST_RELEASE;
        end
        ST_RELEASE: begin
          st.qualZero = 1'b1;
          if (syncLevel[c]) begin
            st.holdZero = 1'b1;        // re-assertion cancels release
            stateD      = ST_ACTIVE;
          end else if (holdDone[c]) begin
            st.holdZero = 1'b1;
            stateD      = ST_IDLE;
          end else begin
            st.holdInc  = 1'b1;
          end
        end
        default: stateD = ST_IDLE;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stateQ <= ST_IDLE;
      else       stateQ <= stateD;
    end

    assign strobe[c]     = st;
    assign chanActive[c] = (stateQ != ST_IDLE);
  end

endmodule

// File: rtl/ctrl_input_qualifier.sv
module ctrl_input_qualifier
  import qual_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 4000,
  parameter int HOLD_CYCLES = 100000,
  parameter int NUM_DEC     = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rawClear,
  input  logic               rawGate,
  input  logic [NUM_DEC-1:0] decisionIn,
  output logic               counterClear,
  output logic [NUM_DEC-1:0] decisionOut
);

  logic [NUM_CHAN-1:0]       rawIn;
  logic [NUM_CHAN-1:0]       syncLevel;
  logic [NUM_CHAN-1:0]       qualDone;
  logic [NUM_CHAN-1:0]       holdDone;
  logic [NUM_CHAN-1:0]       chanActive;
  cntStrobe_t [NUM_CHAN-1:0] strobe;

  assign rawIn[CH_CLEAR] = rawClear;
  assign rawIn[CH_GATE]  = rawGate;

  qual_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .syncLevel  (syncLevel),
    .qualDone   (qualDone),
    .holdDone   (holdDone),
    .strobe     (strobe),
    .chanActive (chanActive)
  );

  qual_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .QUAL_CYCLES (QUAL_CYCLES),
    .HOLD_CYCLES (HOLD_CYCLES),
    .NUM_DEC     (NUM_DEC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .rawIn       (rawIn),
    .strobe      (strobe),
    .gateActive  (chanActive[CH_GATE]),
    .decisionIn  (decisionIn),
    .syncLevel   (syncLevel),
    .qualDone    (qualDone),
    .holdDone    (holdDone),
    .decisionOut (decisionOut)
  );

  assign counterClear = chanActive[CH_CLEAR];

endmodule

// File: rtl/qual_checker.sv
module qual_checker
  import qual_pkg::*;
#(
  parameter int NUM_DEC = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_CHAN-1:0] syncLevel,
  input logic [NUM_CHAN-1:0] chanActive,
  input logic [NUM_DEC-1:0]  decisionIn,
  input logic [NUM_DEC-1:0]  decisionOut
);

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_prop
    // R4: activation only follows a synchronized high level
    a_r4_rise_after_high: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chanActive[c]) |-> $past(syncLevel[c]));
    // R5: deactivation only follows a synchronized low level
    a_r5_fall_after_low: assert property (@(posedge clk) disable iff (!rstN)
      $fell(chanActive[c]) |-> !$past(syncLevel[c]));
    // R6: a high level never lets an active channel drop
    a_r6_high_keeps_active: assert property (@(posedge clk) disable iff (!rstN)
      (chanActive[c] && syncLevel[c]) |=> chanActive[c]);
    // R2: an idle channel with a low level stays idle
    a_r2_low_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
      (!chanActive[c] && !syncLevel[c]) |=> !chanActive[c]);
  end

  // R7: gate override and pass-through
  a_r7_gate_forces_off: assert property (@(posedge clk) disable iff (!rstN)
    chanActive[CH_GATE] |-> (decisionOut == '0));
  a_r7_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    !chanActive[CH_GATE] |-> (decisionOut == decisionIn));

endmodule

bind ctrl_input_qualifier qual_checker #(.NUM_DEC(NUM_DEC)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .syncLevel   (syncLevel),
  .chanActive  (chanActive),
  .decisionIn  (decisionIn),
  .decisionOut (decisionOut)
);

// File: tb/ctrl_input_qualifier_tb.sv
module ctrl_input_qualifier_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int QUAL = 8;
  localparam int HOLD = 20;
  localparam int NDEC = 3;
  localparam int IDLE_GAP = SYNC + QUAL + HOLD + 10;

  typedef struct {
    bit rise;
    int cyc;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawClear = 1'b0;
  logic rawGate = 1'b0;
  logic [NDEC-1:0] decisionIn = '1;
  logic counterClear;
  logic [NDEC-1:0] decisionOut;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  expItem_t qClear[$];
  expItem_t qGate[$];

  ctrl_input_qualifier #(
    .SYNC_STAGES (SYNC),
    .QUAL_CYCLES (QUAL),
    .HOLD_CYCLES (HOLD),
    .NUM_DEC     (NDEC)
  ) u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .rawClear     (rawClear),
    .rawGate      (rawGate),
    .decisionIn   (decisionIn),
    .counterClear (counterClear),
    .decisionOut  (decisionOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_event(input int ch, input bit rise, input int at);
    expItem_t it;
    it.rise = rise;
    it.cyc  = at;
    if (ch == 0) qClear.push_back(it);
    else         qGate.push_back(it);
  endtask

  // Driver: raw line high for exactly len clock samples
  task automatic pulse(input int ch, input int len, input bit qualifies,
                       input bit pushRise, input bit pushFall);
    int c1;
    @(negedge clk);
    if (ch == 0) rawClear = 1'b1; else rawGate = 1'b1;
    c1 = cyc + 1;
    if (qualifies && pushRise) expect_event(ch, 1'b1, c1 + SYNC + QUAL - 1);
    if (qualifies && pushFall) expect_event(ch, 1'b0, c1 + len + SYNC + HOLD);
    repeat (len) @(negedge clk);
    if (ch == 0) rawClear = 1'b0; else rawGate = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string req);
    checks++;
    if (qClear.size() != 0 || qGate.size() != 0) begin
      errors++;
      $display("FAIL %s pending events: actual clear=%0d gate=%0d expected 0",
               req, qClear.size(), qGate.size());
    end
  endtask

  task automatic poke(input logic [NDEC-1:0] pat, input logic [NDEC-1:0] exp,
                      input string req);
    @(negedge clk);
    #1 decisionIn = pat;
    #1;
    checks++;
    if (decisionOut !== exp) begin
      errors++;
      $display("FAIL %s decisionOut actual %b expected %b", req, decisionOut, exp);
    end
    decisionIn = '1;
  endtask

  // Monitor: watch channel edges at the ports and compare with the queues
  bit [1:0] prevObs = 2'b00;
  always @(posedge clk) begin
    bit [1:0] obs;
    expItem_t it;
    #2;
    if (rstN) begin
      obs = {decisionOut == '0, counterClear};
      for (int ch = 0; ch < 2; ch++) begin
        if (obs[ch] != prevObs[ch]) begin
          checks++;
          if ((ch == 0 && qClear.size() == 0) || (ch == 1 && qGate.size() == 0)) begin
            errors++;
            $display("FAIL R2/R3 ch%0d unexpected edge actual rise=%0d at %0d expected none",
                     ch, obs[ch], cyc);
          end else begin
            it = (ch == 0) ? qClear.pop_front() : qGate.pop_front();
            if (it.rise != obs[ch] || it.cyc != cyc) begin
              errors++;
              $display("FAIL R4/R5/R6/R8 ch%0d edge actual rise=%0d at %0d expected rise=%0d at %0d",
                       ch, obs[ch], cyc, it.rise, it.cyc);
            end
          end
        end
      end
      prevObs = obs;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (counterClear !== 1'b0) begin
      errors++;
      $display("FAIL R1 counterClear actual %b expected 0", counterClear);
    end
    poke(3'b010, 3'b010, "R1");

    // R4 R5: minimum qualifying pulse on clear
    pulse(0, QUAL, 1'b1, 1'b1, 1'b1);
    idle(IDLE_GAP);
    drained("R4/R5");

    // R2: one sample short on both channels
    pulse(0, QUAL - 1, 1'b0, 1'b0, 1'b0);
    pulse(1, 1, 1'b0, 1'b0, 1'b0);
    pulse(1, QUAL - 1, 1'b0, 1'b0, 1'b0);
    idle(IDLE_GAP);
    drained("R2");

    // R3: split run does not accumulate
    pulse(0, QUAL - 1, 1'b0, 1'b0, 1'b0);
    pulse(0, QUAL - 1, 1'b0, 1'b0, 1'b0); // one low sample between
    idle(IDLE_GAP);
    drained("R3");

    // R6: re-assertion within hold-off cancels release
    pulse(0, QUAL + 2, 1'b1, 1'b1, 1'b0);
    idle(4);
    pulse(0, 3, 1'b1, 1'b0, 1'b1);
    idle(IDLE_GAP);
    drained("R6");

    // R7: gate forces decisions off, then releases
    fork
      pulse(1, 30, 1'b1, 1'b1, 1'b1);
      begin
        idle(SYNC + QUAL + 3);
        poke(3'b101, 3'b000, "R7");
        poke(3'b011, 3'b000, "R7");
        poke(3'b110, 3'b000, "R7");
      end
    join
    idle(IDLE_GAP);
    poke(3'b101, 3'b101, "R7");
    drained("R7");

    // R8: overlapping pulses on both channels
    fork
      pulse(0, 15, 1'b1, 1'b1, 1'b1);
      begin
        idle(5);
        pulse(1, 9, 1'b1, 1'b1, 1'b1);
      end
    join
    idle(IDLE_GAP);
    drained("R8");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule